// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block picks which ready instructions leave the scheduler in a cycle. The scheduler keeps a separate ready queue for each operation class, and each queue shows the selector only its head: a valid bit, a sequence number and a squashed flag. The selector ranks the valid heads by age, with the smallest sequence number first. It then walks them in that order and issues up to a fixed number of instructions per cycle. No class issues more than one instruction in a cycle.

When the walk reaches a squashed head, that head is popped and the selector moves on without using an issue slot. Next cycle the class competes again with whatever head it shows then. A class whose operation needs a functional unit, and whose unit is not free, is skipped and counted as a conflict, and younger classes are still examined. A class that needs no unit issues whenever the walk reaches it. For every issue that occupies a unit, the block reports how many further cycles the unit stays taken, so the unit pool can keep its busy-until state.

Sequence numbers are compared as plain unsigned values, with no wraparound. A downstream stall blocks the whole walk.

Top module: `isel_issue_sel`

## Requirements
- R1: Grants go to valid, non-squashed classes that are able to issue, in ascending order of head sequence number (unsigned compare). A class is never granted while an older such class that was reached goes ungranted.
- R2: When two heads carry equal sequence numbers, the class with the lower index ranks as older.
- R3: At most ISSUE_W grants (default 2) occur per cycle. Once that many are granted, the walk ends, and heads after that point are neither popped nor counted, even if they are squashed.
- R4: While `stall_i` is high, no pop and no grant occur, and both counters keep their values.
- R5: A squashed head reached by the walk is popped without a grant and without using a slot, and `drop_cnt_o` grows by one for each such head.
- R6: A reached head whose class needs a unit (`unit_need_i`=1) while that unit is not free (`unit_free_i`=0) is neither popped nor granted. Its class slice of `conflict_cnt_o` (bits c*CNT_W upward) grows by one, and younger classes are still examined.
- R7: A class with `unit_need_i`=0 is granted when reached, whatever its `unit_free_i`, and raises no hold report.
- R8: `hold_vld_o[c]` is high exactly when class c is granted and needs a unit. Its `hold_len_o` slice equals op latency minus one when both the op latency and the issue latency exceed 1; otherwise it is 0, because a single-cycle or pipelined unit is free again the next cycle.
- R9: A class whose `head_vld_i` bit is low is never popped, granted or counted.
- R10: After reset, all conflict counters and the drop counter read zero.
- R11: `pop_o` is high for exactly the granted classes plus the dropped squashed classes, and `issue_cnt_o` equals the number of grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Downstream cannot accept issues this cycle |
| head_vld_i | input | NUM_CLASS | Class queue has a ready head |
| head_seq_i | input | NUM_CLASS*SEQ_W | Head sequence number per class, class c at bits c*SEQ_W upward |
| head_sqsh_i | input | NUM_CLASS | Head has been squashed |
| unit_need_i | input | NUM_CLASS | Class operation occupies a functional unit |
| unit_free_i | input | NUM_CLASS | A unit of this class is free this cycle |
| op_lat_i | input | NUM_CLASS*LAT_W | Operation latency per class |
| iss_lat_i | input | NUM_CLASS*LAT_W | Issue latency per class (greater than 1 means not pipelined) |
| pop_o | output | NUM_CLASS | Remove the head of this class queue |
| grant_o | output | NUM_CLASS | Head of this class issues |
| issue_cnt_o | output | $clog2(ISSUE_W+1) | Number of grants this cycle |
| hold_vld_o | output | NUM_CLASS | Busy-until update for this class unit |
| hold_len_o | output | NUM_CLASS*LAT_W | Extra cycles the unit stays occupied |
| conflict_cnt_o | output | NUM_CLASS*CNT_W | Per-class count of skips for lack of a free unit |
| drop_cnt_o | output | CNT_W | Count of squashed heads dropped |

## Verification
The bench runs a set of directed patterns and then a long random phase. One pattern has distinct ages in scrambled class order, which separates true age ranking from index priority. A pattern of equal sequence numbers checks the tie rule. Placing a squashed head in front of live heads shows whether a drop uses up a slot, and placing a squashed head behind a full walk shows whether the walk stops. A blocked-unit head in front of younger ones separates "skip and continue" from "stop at the first failure". The random phase uses a narrow range of sequence numbers, so that ties, stalls, blocked units and latency mixes all collide, and every output is compared with the reference model on every cycle.

// File: rtl/isel_pkg.sv
package isel_pkg;

   // Outcome of the selection walk for one class in one cycle
   typedef enum logic [2:0] {
      ISEL_IDLE     = 3'd0,   // no valid head
      ISEL_SKIPPED  = 3'd1,   // valid, but walk ended before it
      ISEL_ISSUE    = 3'd2,   // granted and popped
      ISEL_DROP     = 3'd3,   // squashed head popped, no slot
      ISEL_CONFLICT = 3'd4    // unit needed but busy
   } walk_res_e;

endpackage

// File: rtl/isel_age_order.sv
module isel_age_order #(
   parameter int NUM_CLASS = 4,
   parameter int SEQ_W     = 16
) (
   input  logic [NUM_CLASS-1:0]                    head_vld_i,
   input  logic [NUM_CLASS*SEQ_W-1:0]              head_seq_i,
   output logic [NUM_CLASS*$clog2(NUM_CLASS)-1:0]  ord_cls_o,
   output logic [NUM_CLASS-1:0]                    ord_vld_o
);
   localparam int IDX_W = $clog2(NUM_CLASS);

   // ahead[c*NUM_CLASS + j] : class j ranks before class c
   logic [NUM_CLASS*NUM_CLASS-1:0] ahead;

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_row
      for (genvar j = 0; j < NUM_CLASS; j++) begin : g_col
         if (j == c) begin : g_self
            assign ahead[c*NUM_CLASS+j] = 1'b0;
         end else if (j < c) begin : g_lower
            // lower index wins a tie
            assign ahead[c*NUM_CLASS+j] = head_vld_i[j] &&
               (head_seq_i[j*SEQ_W +: SEQ_W] <= head_seq_i[c*SEQ_W +: SEQ_W]);
         end else begin : g_upper
            assign ahead[c*NUM_CLASS+j] = head_vld_i[j] &&
               (head_seq_i[j*SEQ_W +: SEQ_W] < head_seq_i[c*SEQ_W +: SEQ_W]);
         end
      end
   end

   // Scatter each valid class into the slot given by its rank
   always_comb begin
      for (int k = 0; k < NUM_CLASS; k++) begin
         ord_vld_o[k]                  = 1'b0;
         ord_cls_o[k*IDX_W +: IDX_W]   = '0;
         for (int c = 0; c < NUM_CLASS; c++) begin
            if (head_vld_i[c] && ($countones(ahead[c*NUM_CLASS +: NUM_CLASS]) == k)) begin
               ord_vld_o[k]                = 1'b1;
               ord_cls_o[k*IDX_W +: IDX_W] = IDX_W'(c);
            end
         end
      end
   end

endmodule

// File: rtl/isel_walk.sv
module isel_walk
   import isel_pkg::*;
#(
   parameter int NUM_CLASS = 4,
   parameter int ISSUE_W   = 2
) (
   input  logic [NUM_CLASS*$clog2(NUM_CLASS)-1:0] ord_cls_i,
   input  logic [NUM_CLASS-1:0]                   ord_vld_i,
   input  logic [NUM_CLASS-1:0]                   sqsh_i,
   input  logic [NUM_CLASS-1:0]                   need_i,
   input  logic [NUM_CLASS-1:0]                   free_i,
   input  logic                                   stall_i,
   output walk_res_e [NUM_CLASS-1:0]              res_o
);
   localparam int IDX_W  = $clog2(NUM_CLASS);
   // With as many slots as classes the width can never run out
   localparam bit CAP_ON = (ISSUE_W < NUM_CLASS);

   always_comb begin
      int                used;
      logic [IDX_W-1:0]  cls;
      used = 0;
      cls  = '0;
      for (int i = 0; i < NUM_CLASS; i++) res_o[i] = ISEL_IDLE;
      for (int k = 0; k < NUM_CLASS; k++) begin
         cls = ord_cls_i[k*IDX_W +: IDX_W];
         if (ord_vld_i[k]) begin
            if (stall_i || (CAP_ON && (used >= ISSUE_W))) begin
               res_o[cls] = ISEL_SKIPPED;
            end else if (sqsh_i[cls]) begin
               res_o[cls] = ISEL_DROP;
            end else if (need_i[cls] && !free_i[cls]) begin
               res_o[cls] = ISEL_CONFLICT;
            end else begin
               res_o[cls] = ISEL_ISSUE;
               used       = used + 1;
            end
         end
      end
   end

endmodule

// File: rtl/isel_hold_calc.sv
module isel_hold_calc #(
   parameter int LAT_W = 4
) (
   input  logic             grant_i,
   input  logic             need_i,
   input  logic [LAT_W-1:0] op_lat_i,
   input  logic [LAT_W-1:0] iss_lat_i,
   output logic             hold_vld_o,
   output logic [LAT_W-1:0] hold_len_o
);
   logic long_op;
   logic unpiped;

   assign long_op    = (op_lat_i > LAT_W'(1));
   assign unpiped    = (iss_lat_i > LAT_W'(1));
   assign hold_vld_o = grant_i && need_i;
   assign hold_len_o = (hold_vld_o && long_op && unpiped) ? (op_lat_i - LAT_W'(1)) : '0;

endmodule

// File: rtl/isel_stat_ctr.sv
module isel_stat_ctr #(
   parameter int NUM_CLASS = 4,
   parameter int CNT_W     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CLASS-1:0]         conflict_i,
   input  logic [NUM_CLASS-1:0]         drop_i,
   output logic [NUM_CLASS*CNT_W-1:0]   conflict_cnt_o,
   output logic [CNT_W-1:0]             drop_cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conflict_cnt_o <= '0;
         drop_cnt_o     <= '0;
      end else begin
         for (int c = 0; c < NUM_CLASS; c++) begin
            if (conflict_i[c]) begin
               conflict_cnt_o[c*CNT_W +: CNT_W] <= conflict_cnt_o[c*CNT_W +: CNT_W] + CNT_W'(1);
            end
         end
         drop_cnt_o <= drop_cnt_o + CNT_W'($countones(drop_i));
      end
   end

endmodule

// File: rtl/isel_issue_sel.sv
module isel_issue_sel
   import isel_pkg::*;
#(
   parameter int NUM_CLASS = 4,
   parameter int ISSUE_W   = 2,
   parameter int SEQ_W     = 16,
   parameter int LAT_W     = 4,
   parameter int CNT_W     = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             stall_i,
   input  logic [NUM_CLASS-1:0]             head_vld_i,
   input  logic [NUM_CLASS*SEQ_W-1:0]       head_seq_i,
   input  logic [NUM_CLASS-1:0]             head_sqsh_i,
   input  logic [NUM_CLASS-1:0]             unit_need_i,
   input  logic [NUM_CLASS-1:0]             unit_free_i,
   input  logic [NUM_CLASS*LAT_W-1:0]       op_lat_i,
   input  logic [NUM_CLASS*LAT_W-1:0]       iss_lat_i,
   output logic [NUM_CLASS-1:0]             pop_o,
   output logic [NUM_CLASS-1:0]             grant_o,
   output logic [$clog2(ISSUE_W+1)-1:0]     issue_cnt_o,
   output logic [NUM_CLASS-1:0]             hold_vld_o,
   output logic [NUM_CLASS*LAT_W-1:0]       hold_len_o,
   output logic [NUM_CLASS*CNT_W-1:0]       conflict_cnt_o,
   output logic [CNT_W-1:0]                 drop_cnt_o
);
   localparam int IDX_W = $clog2(NUM_CLASS);
   localparam int ICW   = $clog2(ISSUE_W+1);

   // Parameter sanity, checked at elaboration
   if (NUM_CLASS < 2) begin : g_bad_classes
      $error("isel_issue_sel: NUM_CLASS must be at least 2");
   end
   if (ISSUE_W < 1 || ISSUE_W > NUM_CLASS) begin : g_bad_width
      $error("isel_issue_sel: ISSUE_W must lie in 1..NUM_CLASS");
   end
   if (SEQ_W < 2 || LAT_W < 2 || CNT_W < 2) begin : g_bad_fields
      $error("isel_issue_sel: SEQ_W, LAT_W and CNT_W must be at least 2");
   end

   logic [NUM_CLASS*IDX_W-1:0] ord_cls;
   logic [NUM_CLASS-1:0]       ord_vld;
   walk_res_e [NUM_CLASS-1:0]  walk_res;
   logic [NUM_CLASS-1:0]       conflict;
   logic [NUM_CLASS-1:0]       drop;

   isel_age_order #(
      .NUM_CLASS (NUM_CLASS),
      .SEQ_W     (SEQ_W)
   ) u_order (
      .head_vld_i (head_vld_i),
      .head_seq_i (head_seq_i),
      .ord_cls_o  (ord_cls),
      .ord_vld_o  (ord_vld)
   );

   isel_walk #(
      .NUM_CLASS (NUM_CLASS),
      .ISSUE_W   (ISSUE_W)
   ) u_walk (
      .ord_cls_i (ord_cls),
      .ord_vld_i (ord_vld),
      .sqsh_i    (head_sqsh_i),
      .need_i    (unit_need_i),
      .free_i    (unit_free_i),
      .stall_i   (stall_i),
      .res_o     (walk_res)
   );

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      assign grant_o[c]  = (walk_res[c] == ISEL_ISSUE);
      assign drop[c]     = (walk_res[c] == ISEL_DROP);
      assign conflict[c] = (walk_res[c] == ISEL_CONFLICT);
      assign pop_o[c]    = grant_o[c] || drop[c];

      isel_hold_calc #(
         .LAT_W (LAT_W)
      ) u_hold (
         .grant_i    (grant_o[c]),
         .need_i     (unit_need_i[c]),
         .op_lat_i   (op_lat_i[c*LAT_W +: LAT_W]),
         .iss_lat_i  (iss_lat_i[c*LAT_W +: LAT_W]),
         .hold_vld_o (hold_vld_o[c]),
         .hold_len_o (hold_len_o[c*LAT_W +: LAT_W])
      );
   end

   assign issue_cnt_o = ICW'($countones(grant_o));

   isel_stat_ctr #(
      .NUM_CLASS (NUM_CLASS),
      .CNT_W     (CNT_W)
   ) u_stats (
      .clk            (clk),
      .rst_n          (rst_n),
      .conflict_i     (conflict),
      .drop_i         (drop),
      .conflict_cnt_o (conflict_cnt_o),
      .drop_cnt_o     (drop_cnt_o)
   );

endmodule

// File: rtl/isel_chk.sv
module isel_chk #(
   parameter int NUM_CLASS = 4,
   parameter int ISSUE_W   = 2,
   parameter int SEQ_W     = 16,
   parameter int LAT_W     = 4,
   parameter int CNT_W     = 16
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           stall_i,
   input logic [NUM_CLASS-1:0]           head_vld_i,
   input logic [NUM_CLASS*SEQ_W-1:0]     head_seq_i,
   input logic [NUM_CLASS-1:0]           head_sqsh_i,
   input logic [NUM_CLASS-1:0]           unit_need_i,
   input logic [NUM_CLASS-1:0]           unit_free_i,
   input logic [NUM_CLASS-1:0]           pop_o,
   input logic [NUM_CLASS-1:0]           grant_o,
   input logic [NUM_CLASS-1:0]           hold_vld_o,
   input logic [NUM_CLASS*CNT_W-1:0]     conflict_cnt_o,
   input logic [CNT_W-1:0]               drop_cnt_o
);
   AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_o) <= ISSUE_W); // R3

   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> (pop_o == '0)); // R4

   AST_STALL_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> ($stable(conflict_cnt_o) && $stable(drop_cnt_o))); // R4

   AST_SQSH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & head_sqsh_i) == '0); // R5

   AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'($countones($past(pop_o & head_sqsh_i))))); // R5

   AST_BUSY_UNIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & unit_need_i & ~unit_free_i) == '0); // R6

   AST_HOLD_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vld_o & ~grant_o) == '0); // R8

   AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_o & ~head_vld_i) == '0); // R9

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_age_c
      for (genvar j = 0; j < NUM_CLASS; j++) begin : g_age_j
         if (j != c) begin : g_pair
            AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
               (grant_o[c] && head_vld_i[j] && !head_sqsh_i[j] &&
                (!unit_need_i[j] || unit_free_i[j]) &&
                ((head_seq_i[j*SEQ_W +: SEQ_W] < head_seq_i[c*SEQ_W +: SEQ_W]) ||
                 ((head_seq_i[j*SEQ_W +: SEQ_W] == head_seq_i[c*SEQ_W +: SEQ_W]) && (j < c))))
               |-> grant_o[j]); // R1 R2
         end
      end
   end

endmodule

bind isel_issue_sel isel_chk #(
   .NUM_CLASS (NUM_CLASS),
   .ISSUE_W   (ISSUE_W),
   .SEQ_W     (SEQ_W),
   .LAT_W     (LAT_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .stall_i        (stall_i),
   .head_vld_i     (head_vld_i),
   .head_seq_i     (head_seq_i),
   .head_sqsh_i    (head_sqsh_i),
   .unit_need_i    (unit_need_i),
   .unit_free_i    (unit_free_i),
   .pop_o          (pop_o),
   .grant_o        (grant_o),
   .hold_vld_o     (hold_vld_o),
   .conflict_cnt_o (conflict_cnt_o),
   .drop_cnt_o     (drop_cnt_o)
);

// File: tb/isel_issue_sel_test.sv
module isel_issue_sel_test;
   localparam int N  = 4;
   localparam int W  = 2;
   localparam int SW = 16;
   localparam int LW = 4;
   localparam int CW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              stall;
   logic [N-1:0]      vld, sqsh, need, free;
   logic [N*SW-1:0]   seq;
   logic [N*LW-1:0]   olat, ilat;
   logic [N-1:0]      pop, grant, hvld;
   logic [1:0]        icnt;
   logic [N*LW-1:0]   hlen;
   logic [N*CW-1:0]   ccnt;
   logic [CW-1:0]     dcnt;

   int total = 0;
   int bad   = 0;
   int m_conf[N];
   int m_drop = 0;

   isel_issue_sel #(
      .NUM_CLASS(N), .ISSUE_W(W), .SEQ_W(SW), .LAT_W(LW), .CNT_W(CW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall),
      .head_vld_i(vld), .head_seq_i(seq), .head_sqsh_i(sqsh),
      .unit_need_i(need), .unit_free_i(free),
      .op_lat_i(olat), .iss_lat_i(ilat),
      .pop_o(pop), .grant_o(grant), .issue_cnt_o(icnt),
      .hold_vld_o(hvld), .hold_len_o(hlen),
      .conflict_cnt_o(ccnt), .drop_cnt_o(dcnt)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit older(input int a, input int b);
      int sa, sb;
      sa = int'(seq[a*SW +: SW]);
      sb = int'(seq[b*SW +: SW]);
      return (sa < sb) || ((sa == sb) && (a < b));
   endfunction

   task automatic clear_all();
      stall = 1'b0; vld = '0; sqsh = '0; need = '0; free = '1; seq = '0;
      for (int c = 0; c < N; c++) begin
         olat[c*LW +: LW] = LW'(1);
         ilat[c*LW +: LW] = LW'(1);
      end
   endtask

   task automatic set_head(input int c, input int s, input bit q, input bit nd, input bit fr);
      vld[c] = 1'b1; seq[c*SW +: SW] = SW'(s); sqsh[c] = q; need[c] = nd; free[c] = fr;
   endtask

   // One cycle: inputs already driven after a falling edge
   task automatic cyc(input string req, input bit use_x, input logic [N-1:0] xg, input logic [N-1:0] xp);
      int ord[N];
      int n, used, tmp, dinc, ol, il;
      int cinc[N];
      logic [N-1:0] g, p, hv;
      logic [N*LW-1:0] hl;
      #3;
      n = 0;
      for (int c = 0; c < N; c++) begin
         cinc[c] = 0;
         ord[c]  = 0;
         if (vld[c]) begin ord[n] = c; n++; end
      end
      for (int a = 0; a < n; a++)
         for (int b = 0; b < n - 1 - a; b++)
            if (older(ord[b+1], ord[b])) begin
               tmp = ord[b]; ord[b] = ord[b+1]; ord[b+1] = tmp;
            end
      g = '0; p = '0; hv = '0; hl = '0; dinc = 0; used = 0;
      for (int k = 0; k < n; k++) begin
         int c;
         c = ord[k];
         if (stall || used >= W) break;
         if (sqsh[c]) begin
            p[c] = 1'b1; dinc++;
         end else if (need[c] && !free[c]) begin
            cinc[c] = 1;
         end else begin
            g[c] = 1'b1; p[c] = 1'b1; used++;
            if (need[c]) begin
               hv[c] = 1'b1;
               ol = int'(olat[c*LW +: LW]);
               il = int'(ilat[c*LW +: LW]);
               if (ol > 1 && il > 1) hl[c*LW +: LW] = LW'(ol - 1);
            end
         end
      end
      chk(grant == g, req, "grant vs model", grant, g);
      chk(pop == p, req, "pop vs model (R11)", pop, p);
      chk(int'(icnt) == used, req, "issue count (R11)", icnt, used);
      chk(hvld == hv, req, "hold valid (R8)", hvld, hv);
      chk(hlen == hl, req, "hold length (R8)", hlen, hl);
      for (int c = 0; c < N; c++)
         chk(int'(ccnt[c*CW +: CW]) == (m_conf[c] & 16'hFFFF), req, "conflict count (R6)",
             ccnt[c*CW +: CW], m_conf[c] & 16'hFFFF);
      chk(int'(dcnt) == (m_drop & 16'hFFFF), req, "drop count (R5)", dcnt, m_drop & 16'hFFFF);
      if (use_x) begin
         chk(grant == xg, req, "directed grant", grant, xg);
         chk(pop == xp, req, "directed pop", pop, xp);
      end
      for (int c = 0; c < N; c++) m_conf[c] += cinc[c];
      m_drop += dinc;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < N; c++) m_conf[c] = 0;
      clear_all();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #3;
      // R10: counters clear under reset
      for (int c = 0; c < N; c++)
         chk(ccnt[c*CW +: CW] == '0, "R10", "reset conflict count", ccnt[c*CW +: CW], 0);
      chk(dcnt == '0, "R10", "reset drop count", dcnt, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: ages in scrambled class order
      clear_all();
      set_head(0, 40, 0, 1, 1); set_head(1, 10, 0, 1, 1);
      set_head(2, 30, 0, 1, 1); set_head(3, 20, 0, 1, 1);
      cyc("R1", 1, 4'b1010, 4'b1010);

      // R2: equal ages resolved by lower index
      clear_all();
      set_head(0, 5, 0, 0, 1); set_head(1, 5, 0, 0, 1);
      set_head(2, 5, 0, 0, 1); set_head(3, 9, 0, 0, 1);
      cyc("R2", 1, 4'b0011, 4'b0011);

      // R5: squashed oldest head takes no slot
      clear_all();
      set_head(0, 1, 1, 1, 1); set_head(1, 2, 0, 1, 1);
      set_head(2, 3, 0, 1, 1); set_head(3, 4, 0, 1, 1);
      cyc("R5", 1, 4'b0110, 4'b0111);
      cyc("R5", 0, '0, '0);

      // R3: walk ends at width, later squashed head stays
      clear_all();
      set_head(0, 1, 0, 1, 1); set_head(1, 2, 0, 1, 1); set_head(2, 3, 1, 1, 1);
      cyc("R3", 1, 4'b0011, 4'b0011);
      cyc("R3", 0, '0, '0);

      // R6: busy unit skipped, younger still issue
      clear_all();
      set_head(0, 1, 0, 1, 0); set_head(1, 2, 0, 1, 1); set_head(2, 3, 0, 1, 1);
      cyc("R6", 1, 4'b0110, 4'b0110);
      cyc("R6", 0, '0, '0);

      // R7: no unit needed, busy flag ignored
      clear_all();
      set_head(0, 1, 0, 0, 0);
      cyc("R7", 1, 4'b0001, 4'b0001);

      // R8: hold lengths for long/pipelined/single-cycle ops
      clear_all();
      set_head(0, 1, 0, 1, 1); set_head(1, 2, 0, 1, 1);
      olat[0*LW +: LW] = 4'd5; ilat[0*LW +: LW] = 4'd3;
      olat[1*LW +: LW] = 4'd5; ilat[1*LW +: LW] = 4'd1;
      cyc("R8", 1, 4'b0011, 4'b0011);
      clear_all();
      set_head(2, 7, 0, 1, 1);
      olat[2*LW +: LW] = 4'd1; ilat[2*LW +: LW] = 4'd4;
      cyc("R8", 1, 4'b0100, 4'b0100);

      // R4: stall freezes everything, counters held
      clear_all();
      set_head(0, 1, 1, 1, 1); set_head(1, 2, 0, 1, 0);
      set_head(2, 3, 0, 1, 1); set_head(3, 4, 0, 1, 1);
      stall = 1'b1;
      cyc("R4", 1, 4'b0000, 4'b0000);
      cyc("R4", 1, 4'b0000, 4'b0000);

      // R9: no valid heads
      clear_all();
      sqsh = '1; need = '1; free = '0;
      cyc("R9", 1, 4'b0000, 4'b0000);
      cyc("R9", 0, '0, '0);

      // R1 R11: random mix, narrow age range for frequent ties
      for (int i = 0; i < 3000; i++) begin
         vld   = N'($urandom);
         sqsh  = N'($urandom) & N'($urandom);
         need  = N'($urandom);
         free  = N'($urandom);
         stall = ($urandom_range(0, 7) == 0);
         for (int c = 0; c < N; c++) begin
            seq[c*SW +: SW]  = SW'($urandom_range(0, 7));
            olat[c*LW +: LW] = LW'($urandom_range(0, 7));
            ilat[c*LW +: LW] = LW'($urandom_range(0, 3));
         end
         cyc("R1", 0, '0, '0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule